// File: doc/BRIEF.md
# Memory Version Tag Checker

This block sits in the path of load and store requests and checks each one against a version tag kept for every 64-byte line. A request carries a 64-bit pointer. A 4-bit reference version sits in bits [63:60], and software may place other metadata in the high bits of the pointer as well. A mask mode sets how many high bits are stripped before the address is used: 8, 16, 24 or 32. The stripped bits are refilled by sign extension of the highest kept bit, which gives the effective address. Bits [13:6] of that address select one of 256 tag entries.

The stored tag is compared with the reference version:
- A stored value of 0 marks an unchecked line, and any access to it passes.
- A stored value of 4'hF marks a line under migration. Any access to it raises a user trap.
- Any other stored value must equal the reference version. Otherwise the access faults.

Software loads tags through a separate write port. A write to a line in the same cycle as a check of that line takes effect first.

Results leave through a one-entry valid/ready output stage. The control has two states:
- **ST_EMPTY**: no result is held.
- **ST_HOLD**: a result is waiting to be taken.

The transitions are:
- ST_EMPTY goes to ST_HOLD when a request is accepted.
- ST_HOLD stays in ST_HOLD when the result is not taken, or when it is taken and a new request is accepted in the same cycle.
- ST_HOLD goes to ST_EMPTY when the result is taken and no request arrives.

On every fault or trap, the effective address and both versions are latched into status outputs.

Top module: `vtc_checker`

## Requirements
- R1: A request is accepted when `req_valid` and `req_ready` are both high. `req_ready` is high whenever no result is held, or the held result is being taken. The result is valid in the cycle after acceptance and stays stable until `rsp_ready` takes it.
- R2: `cfg_mask_mode` values 00, 01, 10 and 11 keep the low 56, 48, 40 and 32 pointer bits in `rsp_addr`. Every higher bit of `rsp_addr` is a copy of the highest kept bit.
- R3: The tag entry is selected by effective-address bits [13:6]. Bits [5:0] never change which entry is used and are passed through unchanged.
- R4: When the stored tag is neither 0 nor 4'hF and equals pointer bits [63:60], the result is pass.
- R5: When the stored tag is neither 0 nor 4'hF and differs from pointer bits [63:60], the result is a fault.
- R6: A stored tag of 0 always gives pass, whatever the reference version.
- R7: A stored tag of 4'hF always gives a trap, including when the reference version also differs. The trap takes priority over a fault.
- R8: Each result asserts exactly one of `rsp_pass`, `rsp_fault` and `rsp_trap`.
- R9: On a fault or trap, `stat_addr`, `stat_ref_ver` and `stat_mem_ver` capture the effective address, the reference version and the stored version. A passing result leaves them unchanged.
- R10: A tag write to the same line in the same cycle as an accepted check is applied before that check.
- R11: After reset, no result is held, `req_ready` is high, every tag is 0 and the status outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mask_mode | input | 2 | Number of stripped high pointer bits (8/16/24/32) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_ptr | input | 64 | Pointer with reference version in [63:60] |
| tw_en | input | 1 | Tag write strobe |
| tw_line | input | 8 | Line index to write |
| tw_ver | input | 4 | Tag value to write |
| rsp_valid | output | 1 | Result held |
| rsp_ready | input | 1 | Downstream takes result |
| rsp_addr | output | 64 | Effective address |
| rsp_pass | output | 1 | Access allowed |
| rsp_fault | output | 1 | Version mismatch |
| rsp_trap | output | 1 | Line is migrating |
| stat_addr | output | 64 | Address of last fault or trap |
| stat_ref_ver | output | 4 | Reference version of last fault or trap |
| stat_mem_ver | output | 4 | Stored version of last fault or trap |

## Verification
A check result is due one clock edge after acceptance, and the status outputs change at that same edge. A tag write becomes visible to a check accepted at the same edge or any later edge. The driver pushes the expected result at the edge where it sees acceptance, using a model of the tags that applies same-cycle writes first. The monitor samples on the falling edge and pops one entry only where valid and ready are both high, so held results under backpressure are never counted twice. Status values are compared after the output drains, against the values recorded for the last fault or trap.

// File: rtl/vtc_pkg.sv
`timescale 1ns/1ps
package vtc_pkg;
    typedef enum logic {
        ST_EMPTY,
        ST_HOLD
    } vtc_state_e;

    typedef struct packed {
        logic pass;
        logic fault;
        logic trap;
    } vtc_verdict_t;
endpackage

// File: rtl/vtc_addr_mask.sv
`timescale 1ns/1ps
module vtc_addr_mask #(
    parameter int AW     = 64,
    parameter int MODE_W = 2,
    parameter int STEP   = 8
) (
    input  logic [AW-1:0]     ptr,
    input  logic [MODE_W-1:0] mode,
    output logic [AW-1:0]     eff
);
    localparam int NMODES = 1 << MODE_W;

    logic [AW-1:0] cand [NMODES];

    // each mode strips (mode+1)*STEP high bits and sign-extends the rest
    for (genvar m = 0; m < NMODES; m++) begin : g_mode
        localparam int KEEP = AW - (m + 1) * STEP;
        assign cand[m] = {{(AW-KEEP){ptr[KEEP-1]}}, ptr[KEEP-1:0]};
    end

    assign eff = cand[mode];
endmodule

// File: rtl/vtc_tag_store.sv
`timescale 1ns/1ps
module vtc_tag_store #(
    parameter int IDX_W = 8,
    parameter int VER_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [VER_W-1:0] wver,
    input  logic [IDX_W-1:0] ridx,
    output logic [VER_W-1:0] rver
);
    localparam int DEPTH = 1 << IDX_W;

    logic [VER_W-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[widx] <= wver;
        end
    end

    // same-line write wins over the stored value for this cycle's lookup
    assign rver = (we && (widx == ridx)) ? wver : mem[ridx];
endmodule

// File: rtl/vtc_compare.sv
`timescale 1ns/1ps
module vtc_compare
    import vtc_pkg::*;
#(
    parameter int VER_W = 4
) (
    input  logic [VER_W-1:0] ref_ver,
    input  logic [VER_W-1:0] mem_ver,
    output vtc_verdict_t     verdict
);
    localparam logic [VER_W-1:0] MIGRATING = '1;
    localparam logic [VER_W-1:0] UNCHECKED = '0;

    always_comb begin
        verdict = '0;
        if (mem_ver == MIGRATING)
            verdict.trap = 1'b1;
        else if ((mem_ver != UNCHECKED) && (mem_ver != ref_ver))
            verdict.fault = 1'b1;
        else
            verdict.pass = 1'b1;
    end
endmodule

// File: rtl/vtc_checker.sv
`timescale 1ns/1ps
module vtc_checker
    import vtc_pkg::*;
#(
    parameter int AW       = 64,
    parameter int VER_W    = 4,
    parameter int LINE_OFF = 6,
    parameter int IDX_W    = 8,
    parameter int MODE_W   = 2,
    parameter int STEP     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] cfg_mask_mode,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [AW-1:0]     req_ptr,
    input  logic              tw_en,
    input  logic [IDX_W-1:0]  tw_line,
    input  logic [VER_W-1:0]  tw_ver,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [AW-1:0]     rsp_addr,
    output logic              rsp_pass,
    output logic              rsp_fault,
    output logic              rsp_trap,
    output logic [AW-1:0]     stat_addr,
    output logic [VER_W-1:0]  stat_ref_ver,
    output logic [VER_W-1:0]  stat_mem_ver
);
    localparam int VER_LSB = AW - VER_W;

    vtc_state_e   state_q, state_d;
    logic         accept;
    logic [AW-1:0]    eff_addr;
    logic [VER_W-1:0] ref_ver, mem_ver;
    vtc_verdict_t verdict, verdict_q;

    assign ref_ver   = req_ptr[AW-1:VER_LSB];
    assign req_ready = (state_q == ST_EMPTY) || rsp_ready;
    assign accept    = req_valid && req_ready;

    vtc_addr_mask #(.AW(AW), .MODE_W(MODE_W), .STEP(STEP)) u_mask (
        .ptr  (req_ptr),
        .mode (cfg_mask_mode),
        .eff  (eff_addr)
    );

    vtc_tag_store #(.IDX_W(IDX_W), .VER_W(VER_W)) u_tags (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (tw_en),
        .widx  (tw_line),
        .wver  (tw_ver),
        .ridx  (eff_addr[LINE_OFF +: IDX_W]),
        .rver  (mem_ver)
    );

    vtc_compare #(.VER_W(VER_W)) u_cmp (
        .ref_ver (ref_ver),
        .mem_ver (mem_ver),
        .verdict (verdict)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (accept) state_d = ST_HOLD;
            ST_HOLD:  if (rsp_ready && !accept) state_d = ST_EMPTY;
            default:  state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_addr     <= '0;
            verdict_q    <= '0;
            stat_addr    <= '0;
            stat_ref_ver <= '0;
            stat_mem_ver <= '0;
        end else if (accept) begin
            rsp_addr  <= eff_addr;
            verdict_q <= verdict;
            if (!verdict.pass) begin
                stat_addr    <= eff_addr;
                stat_ref_ver <= ref_ver;
                stat_mem_ver <= mem_ver;
            end
        end
    end

    assign rsp_valid = (state_q == ST_HOLD);
    assign rsp_pass  = verdict_q.pass;
    assign rsp_fault = verdict_q.fault;
    assign rsp_trap  = verdict_q.trap;
endmodule

// File: rtl/vtc_checker_sva.sv
`timescale 1ns/1ps
module vtc_checker_sva #(
    parameter int AW    = 64,
    parameter int VER_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [AW-1:0]    req_ptr,
    input logic             rsp_valid,
    input logic             rsp_ready,
    input logic [AW-1:0]    rsp_addr,
    input logic             rsp_pass,
    input logic             rsp_fault,
    input logic             rsp_trap,
    input logic [VER_W-1:0] stat_ref_ver,
    input logic [VER_W-1:0] stat_mem_ver
);
    assert_ready_free_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> req_ready);

    assert_result_next_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);

    assert_hold_stable_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_addr)
            && $stable({rsp_pass, rsp_fault, rsp_trap})));

    assert_top_extended_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ((rsp_addr[AW-1:AW-9] == '0) || (rsp_addr[AW-1:AW-9] == '1)));

    assert_offset_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (rsp_addr[5:0] == $past(req_ptr[5:0])));

    assert_fault_status_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> ((stat_ref_ver != stat_mem_ver) && (stat_mem_ver != '0)));

    assert_one_verdict_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($countones({rsp_pass, rsp_fault, rsp_trap}) == 1));

    assert_trap_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_trap) |-> (stat_mem_ver == '1));
endmodule

bind vtc_checker vtc_checker_sva #(.AW(AW), .VER_W(VER_W)) u_sva (.*);

// File: tb/vtc_checker_tb.sv
`timescale 1ns/1ps
module vtc_checker_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_mask_mode = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_ptr = '0;
    logic        tw_en = 1'b0;
    logic [7:0]  tw_line = '0;
    logic [3:0]  tw_ver = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic [63:0] rsp_addr;
    logic        rsp_pass, rsp_fault, rsp_trap;
    logic [63:0] stat_addr;
    logic [3:0]  stat_ref_ver, stat_mem_ver;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [3:0]  model [256];
    logic [66:0] expq [$];   // {addr, pass, fault, trap}
    logic [63:0] exp_saddr = '0;
    logic [3:0]  exp_sref = '0, exp_smem = '0;

    always #4 clk = ~clk;    // 125 MHz

    vtc_checker u_dut (.*);

    task automatic chk(input bit ok, input string req, input logic [66:0] act, input logic [66:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] mask_addr(input logic [63:0] p, input logic [1:0] m);
        int sh = 8 * (int'(m) + 1);
        return 64'($signed(p) <<< sh) >>> sh == 0 ? 64'($signed(64'($signed(p) <<< sh)) >>> sh)
                                                : 64'($signed(64'($signed(p) <<< sh)) >>> sh);
    endfunction

    task automatic wr(input logic [7:0] line, input logic [3:0] ver);
        @(posedge clk); #1;
        tw_en = 1'b1; tw_line = line; tw_ver = ver;
        @(posedge clk);
        model[line] = ver;
        #1 tw_en = 1'b0;
    endtask

    task automatic send(input logic [63:0] p, input logic [1:0] m,
                        input bit we, input logic [7:0] wl, input logic [3:0] wv);
        bit rdy;
        logic [63:0] ea;
        logic [3:0]  mv, rv;
        bit tr, fl;
        @(posedge clk); #1;
        req_valid = 1'b1; req_ptr = p; cfg_mask_mode = m;
        tw_en = we; tw_line = wl; tw_ver = wv;
        do begin
            @(negedge clk); rdy = req_ready;
            @(posedge clk);
        end while (!rdy);
        if (we) model[wl] = wv;        // R10: write lands before the check
        ea = mask_addr(p, m);
        mv = model[ea[13:6]];
        rv = p[63:60];
        tr = (mv == 4'hF);
        fl = !tr && (mv != 4'h0) && (mv != rv);
        expq.push_back({ea, !tr && !fl, fl, tr});
        if (tr || fl) begin exp_saddr = ea; exp_sref = rv; exp_smem = mv; end
        #1 req_valid = 1'b0; tw_en = 1'b0;
    endtask

    task automatic drain();
        do @(negedge clk); while (expq.size() != 0 || rsp_valid);
    endtask

    task automatic chk_status(input string req);
        chk(stat_addr == exp_saddr && stat_ref_ver == exp_sref && stat_mem_ver == exp_smem, req,
            {stat_addr, stat_ref_ver[2:0]}, {exp_saddr, exp_sref[2:0]});
        chk(stat_ref_ver == exp_sref && stat_mem_ver == exp_smem, req,
            67'({stat_ref_ver, stat_mem_ver}), 67'({exp_sref, exp_smem}));
    endtask

    // monitor: one transfer per cycle where valid and ready meet
    always @(negedge clk) begin
        if (rst_n && rsp_valid && rsp_ready && !done) begin
            logic [66:0] e, a;
            a = {rsp_addr, rsp_pass, rsp_fault, rsp_trap};
            if (expq.size() == 0) begin
                chk(1'b0, "R1 unexpected result", a, '0);
            end else begin
                e = expq.pop_front();
                chk(a == e, "R2/R4/R5/R6/R7/R8 result", a, e);
            end
        end
    end

    initial begin
        #(8 * 50000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) model[i] = 4'h0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk(!rsp_valid && req_ready, "R11 handshake after reset", 67'({rsp_valid, req_ready}), 67'b01);
        chk(stat_addr == 0 && stat_ref_ver == 0 && stat_mem_ver == 0, "R11 status after reset",
            67'(stat_addr), '0);

        // R6: unchecked line (tag 0) passes for any reference version
        send(64'h5000_0000_0000_00C0, 2'd0, 0, 0, 0);
        send(64'hA000_0000_0000_00C4, 2'd0, 0, 0, 0);

        // R4 / R5: line 3 tagged 5
        wr(8'd3, 4'h5);
        send(64'h5000_0000_0000_00C0, 2'd0, 0, 0, 0);
        send(64'h6000_0000_0000_00C8, 2'd0, 0, 0, 0);
        drain();
        chk_status("R9 status after fault R5");

        // R3: offset bits [5:0] do not change entry; other line index does
        send(64'h6000_0000_0000_00FF, 2'd0, 0, 0, 0);
        send(64'h6000_0000_0000_0100, 2'd0, 0, 0, 0);
        send(64'h5000_0000_0000_40C1, 2'd0, 0, 0, 0);

        // R7: migrating line traps, also with mismatching reference
        wr(8'd9, 4'hF);
        send(64'hF000_0000_0000_0240, 2'd1, 0, 0, 0);
        send(64'h2000_0000_0000_0248, 2'd2, 0, 0, 0);
        drain();
        chk_status("R9 status after trap R7");
        // R9: a pass leaves status alone
        send(64'h1000_0000_0000_0440, 2'd0, 0, 0, 0);
        drain();
        chk_status("R9 status kept on pass");

        // R10: same-cycle write to the checked line applies first
        send(64'h7000_0000_0000_0500, 2'd0, 1, 8'd20, 4'h3);
        send(64'h7000_0000_0000_0540, 2'd0, 1, 8'd21, 4'hF);
        drain();
        chk_status("R10 status after same-cycle trap");

        // R2: each mask mode, both signs of the top kept bit
        for (int m = 0; m < 4; m++) begin
            send(64'h5A12_3456_789A_BCC0, 2'(m), 0, 0, 0);
            send(64'h30FF_FFFF_FFFF_0FC0, 2'(m), 0, 0, 0);
            send(64'h3080_0000_8000_0040, 2'(m), 0, 0, 0);
        end
        drain();

        // R1: backpressure holds the result and blocks new requests
        #1 rsp_ready = 1'b0;
        send(64'h6000_0000_0000_00C0, 2'd0, 0, 0, 0);
        repeat (3) @(negedge clk);
        chk(rsp_valid && !req_ready && rsp_fault, "R1 result held under backpressure",
            67'({rsp_valid, req_ready, rsp_fault}), 67'b101);
        @(posedge clk); #1 rsp_ready = 1'b1;
        drain();
        chk(!rsp_valid && req_ready, "R1 output empties after take",
            67'({rsp_valid, req_ready}), 67'b01);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule